// File: doc/BRIEF.md
# Transmit-Side General-Purpose Output Source Router

This block drives the general-purpose output pins on the transmit end of a camera link. Each pin takes its value from one of two places. One is a value forwarded from the matching GPIO at the far end of the link. The other is a bit of a local control register. A per-pin select bit chooses between them. Forwarded values arrive with a valid strobe. Each one is held in a register until the next strobe, so a pin that follows the far end changes only when a new update lands.

A clock-source mode input reassigns two of the pins. When the external-oscillator mode is on, the clock-input pin stops driving and serves as the input for an external reference clock. The divided-output pin then carries that reference divided by two, for use as the imager's clock. Both pins ignore their select and data bits in this mode. The block also reports which far-end channels can still take part in forwarding, so upstream logic can avoid routing a value to a pin that has been taken over.

Top module: `gpo_source_router`

## Requirements
- R1: While reset is asserted and right after it, every bit of `gpo_out` is 0, and the held forwarded values are 0.
- R2: For a pin in normal use, `sel_remote` bit = 1 routes the held forwarded value for that pin and bit = 0 routes the `local_bits` bit. `gpo_out` is registered: it shows the source sampled at the previous rising `clk` edge.
- R3: `fwd_bits` is captured only on a `clk` edge where `fwd_valid` is 1. When `fwd_valid` is 0, changes on `fwd_bits` leave every remote-selected pin unchanged.
- R4: A forwarded value sampled with `fwd_valid` at one rising edge appears on a remote-selected pin after the next rising edge (two edges in total). This keeps forwarding far faster than a 66 kHz toggle rate.
- R5: With `ext_osc_mode` = 0, `gpo_oe` is all ones: every pin is an output, and no pin ever carries a value toward the far end.
- R6: With `ext_osc_mode` = 1, pin 3 (the clock input) has `gpo_oe[3]` = 0 and `gpo_out[3]` = 0, whatever its select or local bit says.
- R7: With `ext_osc_mode` = 1, `gpo_out[2]` equals a toggle flip-flop that reset clears and that flips on every rising edge of `refclk_in`, whatever the select, local or forwarded bits of pin 2 say.
- R8: `fwd_avail` is all ones when `ext_osc_mode` = 0. When `ext_osc_mode` = 1, bits 2 and 3 are 0 and the other bits stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_osc_mode | input | 1 | 1 = external-oscillator clock mode |
| fwd_valid | input | 1 | Strobe marking a new forwarded GPIO word |
| fwd_bits | input | 4 | Forwarded far-end GPIO values |
| sel_remote | input | 4 | Per-pin source select, 1 = forwarded, 0 = local |
| local_bits | input | 4 | Local control register bits |
| refclk_in | input | 1 | External reference clock arriving on pin 3 |
| gpo_out | output | 4 | Pin output values |
| gpo_oe | output | 4 | Pin output enables |
| fwd_avail | output | 4 | Far-end channels still usable for forwarding |

## Verification
The bench builds the block with its defaults: four pins, pin 3 as the clock input, pin 2 as the divided output, and the clock-mode variant enabled. This gives the generate branch that contains the divider and the pin takeover, where most corner cases sit. Random vectors switch the mode, the selects, the local bits and the strobe, and they add bursts of reference-clock pulses. As a result, divider parity, mode changes with stale selects, and held-but-not-strobed data all get exercised. Directed cases cover the reset state, the two-edge forwarding latency, and the rule that a strobe is ignored unless it is valid.

// File: rtl/gpo_router_pkg.sv
package gpo_router_pkg;

   typedef enum logic [1:0] {
      ROLE_LOCAL  = 2'd0,
      ROLE_REMOTE = 2'd1,
      ROLE_CLKIN  = 2'd2,
      ROLE_DIVOUT = 2'd3
   } pin_role_e;

   // Role of one pin from the mode, its select and its position.
   function automatic pin_role_e pick_role(input logic ext, input logic sel,
                                           input int idx, input int clkin_idx,
                                           input int divout_idx);
      if (ext && idx == clkin_idx)  return ROLE_CLKIN;
      if (ext && idx == divout_idx) return ROLE_DIVOUT;
      if (sel)                      return ROLE_REMOTE;
      return ROLE_LOCAL;
   endfunction

endpackage

// File: rtl/gpo_fwd_hold.sv
module gpo_fwd_hold #(
   parameter int WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fwd_valid,
   input  logic [WIDTH-1:0] fwd_bits,
   output logic [WIDTH-1:0] held
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         held <= '0;
      else if (fwd_valid) held <= fwd_bits;
   end

   // R3: without a strobe the held word does not move
   a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_valid |=> $stable(held));

   // R3: with a strobe the word sampled is the one kept
   a_r3_capture_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> held == $past(fwd_bits));

endmodule

// File: rtl/gpo_clk_halver.sv
module gpo_clk_halver (
   input  logic refclk_in,
   input  logic rst_n,
   output logic div_q
);

   always_ff @(posedge refclk_in or negedge rst_n) begin
      if (!rst_n) div_q <= 1'b0;
      else        div_q <= ~div_q;
   end

   // R7: every reference edge flips the halved clock
   a_r7_toggles: assert property (@(posedge refclk_in) disable iff (!rst_n)
      1'b1 |=> div_q != $past(div_q));

endmodule

// File: rtl/gpo_pin_mux.sv
module gpo_pin_mux
   import gpo_router_pkg::*;
#(
   parameter int NUM_PINS   = 4,
   parameter int CLKIN_PIN  = 3,
   parameter int DIVOUT_PIN = 2,
   parameter bit CLK_MODE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_osc_mode,
   input  logic [NUM_PINS-1:0] sel_remote,
   input  logic [NUM_PINS-1:0] local_bits,
   input  logic [NUM_PINS-1:0] held,
   input  logic                div_q,
   output logic [NUM_PINS-1:0] gpo_out,
   output logic [NUM_PINS-1:0] gpo_oe,
   output logic [NUM_PINS-1:0] fwd_avail
);

   logic                ext_eff;
   logic [NUM_PINS-1:0] out_q;

   assign ext_eff = CLK_MODE ? ext_osc_mode : 1'b0;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pin_role_e role;
      logic      next_val;

      always_comb begin
         role = pick_role(ext_eff, sel_remote[i], i, CLKIN_PIN, DIVOUT_PIN);
         unique case (role)
            ROLE_REMOTE: next_val = held[i];
            ROLE_LOCAL:  next_val = local_bits[i];
            default:     next_val = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_q[i] <= 1'b0;
         else        out_q[i] <= next_val;
      end

      if (CLK_MODE && i == DIVOUT_PIN) begin : g_div
         assign gpo_out[i] = (role == ROLE_DIVOUT) ? div_q : out_q[i];
      end else begin : g_plain
         assign gpo_out[i] = out_q[i];
      end

      assign gpo_oe[i]    = (role != ROLE_CLKIN);
      assign fwd_avail[i] = (role != ROLE_CLKIN) && (role != ROLE_DIVOUT);
   end

   // R6: the clock-input pin never drives in oscillator mode
   a_r6_clkin_released: assert property (@(posedge clk) disable iff (!rst_n)
      ext_eff |-> !gpo_oe[CLKIN_PIN]);

   // R8: taken-over channels are reported unusable
   a_r8_avail_masked: assert property (@(posedge clk) disable iff (!rst_n)
      ext_eff |-> !fwd_avail[CLKIN_PIN] && !fwd_avail[DIVOUT_PIN]);

   // R5: in internal-clock mode every pin is an output
   a_r5_all_driven: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_eff |-> &gpo_oe);

   // R2: pin 0 follows the held forwarded bit when selected
   a_r2_remote_follow: assert property (@(posedge clk) disable iff (!rst_n)
      sel_remote[0] |=> gpo_out[0] == $past(held[0]));

   // R2: pin 0 follows the local bit when not selected
   a_r2_local_follow: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_remote[0] |=> gpo_out[0] == $past(local_bits[0]));

endmodule

// File: rtl/gpo_source_router.sv
module gpo_source_router #(
   parameter int NUM_PINS   = 4,
   parameter int CLKIN_PIN  = 3,
   parameter int DIVOUT_PIN = 2,
   parameter bit CLK_MODE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ext_osc_mode,
   input  logic                fwd_valid,
   input  logic [NUM_PINS-1:0] fwd_bits,
   input  logic [NUM_PINS-1:0] sel_remote,
   input  logic [NUM_PINS-1:0] local_bits,
   input  logic                refclk_in,
   output logic [NUM_PINS-1:0] gpo_out,
   output logic [NUM_PINS-1:0] gpo_oe,
   output logic [NUM_PINS-1:0] fwd_avail
);

   localparam int PIN_IDX_MAX = NUM_PINS - 1;

   if (NUM_PINS < 2) begin : g_bad_count
      $error("gpo_source_router: NUM_PINS must be at least 2");
   end
   if (CLKIN_PIN > PIN_IDX_MAX || DIVOUT_PIN > PIN_IDX_MAX) begin : g_bad_index
      $error("gpo_source_router: clock pin index out of range");
   end
   if (CLKIN_PIN == DIVOUT_PIN) begin : g_bad_pair
      $error("gpo_source_router: clock pins must differ");
   end

   logic [NUM_PINS-1:0] held;
   logic                div_q;

   gpo_fwd_hold #(.WIDTH(NUM_PINS)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .fwd_valid (fwd_valid),
      .fwd_bits  (fwd_bits),
      .held      (held)
   );

   if (CLK_MODE) begin : g_halver
      gpo_clk_halver u_halver (
         .refclk_in (refclk_in),
         .rst_n     (rst_n),
         .div_q     (div_q)
      );
   end else begin : g_no_halver
      assign div_q = 1'b0;
   end

   gpo_pin_mux #(
      .NUM_PINS   (NUM_PINS),
      .CLKIN_PIN  (CLKIN_PIN),
      .DIVOUT_PIN (DIVOUT_PIN),
      .CLK_MODE   (CLK_MODE)
   ) u_mux (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_osc_mode (ext_osc_mode),
      .sel_remote   (sel_remote),
      .local_bits   (local_bits),
      .held         (held),
      .div_q        (div_q),
      .gpo_out      (gpo_out),
      .gpo_oe       (gpo_oe),
      .fwd_avail    (fwd_avail)
   );

endmodule

// File: tb/gpo_source_router_tb.sv
module gpo_source_router_tb_top;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ext_osc_mode = 1'b0;
   logic         fwd_valid = 1'b0;
   logic [N-1:0] fwd_bits = '0;
   logic [N-1:0] sel_remote = '0;
   logic [N-1:0] local_bits = '0;
   logic         refclk_in = 1'b0;
   logic [N-1:0] gpo_out, gpo_oe, fwd_avail;

   int n_chk = 0;
   int n_fail = 0;
   logic [N-1:0] m_held = '0;
   int           m_pulses = 0;

   always #10 clk = ~clk;

   gpo_source_router dut_i (
      .clk(clk), .rst_n(rst_n), .ext_osc_mode(ext_osc_mode),
      .fwd_valid(fwd_valid), .fwd_bits(fwd_bits), .sel_remote(sel_remote),
      .local_bits(local_bits), .refclk_in(refclk_in),
      .gpo_out(gpo_out), .gpo_oe(gpo_oe), .fwd_avail(fwd_avail));

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic exp_pin(input int i);
      if (ext_osc_mode && i == 3) return 1'b0;
      if (ext_osc_mode && i == 2) return logic'(m_pulses % 2);
      return sel_remote[i] ? m_held[i] : local_bits[i];
   endfunction

   task automatic pulse_ref(input int n);
      for (int k = 0; k < n; k++) begin
         #2 refclk_in = 1'b1;
         #2 refclk_in = 1'b0;
         m_pulses++;
      end
   endtask

   task automatic check_all();
      chk("R2 pins 0-1", {2'b00, gpo_out[1:0]}, {2'b00, exp_pin(1), exp_pin(0)});
      if (ext_osc_mode) begin
         chk("R7 divided pin", {3'b000, gpo_out[2]}, {3'b000, exp_pin(2)});
         chk("R6 clock-in pin", {2'b00, gpo_out[3], gpo_oe[3]}, 4'b0000);
         chk("R8 avail masked", fwd_avail, 4'b0011);
      end else begin
         chk("R2 pins 2-3", {2'b00, gpo_out[3:2]}, {2'b00, exp_pin(3), exp_pin(2)});
         chk("R5 all outputs", gpo_oe, 4'b1111);
         chk("R8 avail full", fwd_avail, 4'b1111);
      end
   endtask

   // Drive one vector at a negedge, clear strobe one cycle later, check after two edges.
   task automatic apply(input logic ext, input logic vld, input logic [N-1:0] fb,
                        input logic [N-1:0] sel, input logic [N-1:0] loc, input int pulses);
      @(negedge clk);
      ext_osc_mode = ext; fwd_valid = vld; fwd_bits = fb;
      sel_remote = sel; local_bits = loc;
      if (vld) m_held = fb;
      @(negedge clk);
      fwd_valid = 1'b0;
      if (ext) pulse_ref(pulses);
      @(negedge clk);
      check_all();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'h1F2E));
      local_bits = 4'hF; sel_remote = 4'h0;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", gpo_out, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      local_bits = 4'h0;
      sel_remote = 4'hF;
      @(negedge clk); @(negedge clk);
      chk("R1 held cleared", gpo_out, 4'b0000);

      // R4: latency of a forwarded word
      @(negedge clk);
      fwd_bits = 4'b1011; fwd_valid = 1'b1; m_held = 4'b1011;
      @(negedge clk);
      fwd_valid = 1'b0;
      chk("R4 not yet after one edge", gpo_out, 4'b0000);
      @(negedge clk);
      chk("R4 arrived after two edges", gpo_out, 4'b1011);

      // R3: data without strobe is ignored
      @(negedge clk);
      fwd_bits = 4'b0100;
      repeat (3) @(negedge clk);
      chk("R3 no strobe no change", gpo_out, 4'b1011);

      // R6/R7: oscillator mode overrides selects and data
      apply(1'b1, 1'b1, 4'b1111, 4'b1111, 4'b1111, 3);
      apply(1'b1, 1'b0, 4'b0000, 4'b0000, 4'b1100, 2);
      apply(1'b0, 1'b0, 4'b0000, 4'b0000, 4'b1010, 0);

      for (int v = 0; v < 300; v++) begin
         apply(1'($urandom % 2), 1'($urandom % 2), 4'($urandom), 4'($urandom),
               4'($urandom), int'($urandom % 4));
      end
      finish_run();
   end

endmodule